// File: doc/BRIEF.md
# Key-Protected Watchdog Reset Timer

This block is a watchdog timer for a chip that keeps a slow 32 kHz reference alive. The reference arrives as a one-cycle enable on the fast system clock. Software programs the watchdog through a small register port with four 32-bit registers. Every write must carry a fixed key pattern, so a stray store from runaway code cannot disable the timer or change its period.

A prescaler turns the reference enables into coarse ticks. A down-counter loaded from the programmed length then counts those ticks while the watchdog is enabled. If software does not write the restart code in time, the counter expires. What happens next depends on the mode:

- In plain mode the block drives a reset pulse of fixed length.
- In interrupt mode it raises a sticky interrupt instead.
- In dual mode a second expiry, with the interrupt still pending, then drives the reset pulse.

A separate register forces the reset pulse at once, whether or not the watchdog is enabled.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, enable and every other mode bit read as 0, the length field holds its all-ones maximum, the counter holds that same maximum, and `rstOut` and `irqOut` are low.
- R2: A write to offset 0x00 (mode) is accepted only when `wdata[31:24]` equals 0x22; any other upper byte leaves the mode register unchanged. The fields are bit 0 enable, bit 2 reset-output enable, bit 3 interrupt mode and bit 6 dual mode.
- R3: A write to offset 0x04 (length) is accepted only when `wdata[4:0]` equals 0x08. The timeout count is `wdata[5 +: LEN_W]`, and higher bits are ignored.
- R4: The read port returns the following, all combinationally from `addr`:
  - at 0x00, the mode fields in their write positions with all other bits zero;
  - at 0x04, the stored count shifted left by 5 with bits [4:0] zero;
  - at every other offset, including 0x08 and 0x14, zero.
- R5: While enabled, each `refTick` advances a PRESCALE_W-bit prescaler, and every 2^PRESCALE_W-th `refTick` is one tick. Expiry happens on the L-th tick after the counter is loaded with length L (L ≥ 1), and the counter then reloads from the length and keeps running.
- R6: Writing exactly 0x1971 to offset 0x08 reloads the counter from the length, clears the prescaler and clears a pending interrupt. Any other value written there has no effect on timing.
- R7: While enable is 0, the prescaler and the counter hold their values. Enabling again resumes from the held state.
- R8: On an expiry with interrupt mode 0 and reset-output enable 1, `rstOut` goes high on the following cycle and stays high for RST_PULSE `refTick`s. With reset-output enable 0, an expiry never raises `rstOut`.
- R9: With interrupt mode 1 and dual mode 0, an expiry sets `irqOut`, which stays high until a restart. Further expiries do not raise `rstOut`.
- R10: With interrupt mode 1 and dual mode 1, the first expiry sets `irqOut`. An expiry while `irqOut` is still high raises `rstOut`, provided reset-output enable is 1.
- R11: Writing exactly 0x1209 to offset 0x14 raises `rstOut` on the following cycle regardless of the mode bits. Any other value written there is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| refTick | input | 1 | One-cycle enable at the 32 kHz reference rate |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset for both reads and writes |
| wdata | input | 32 | Write data, including the key pattern |
| rdata | output | 32 | Read data for `addr` |
| rstOut | output | 1 | Reset request pulse |
| irqOut | output | 1 | Watchdog interrupt, sticky until restart |

## Verification
The bench builds the block with PRESCALE_W = 2 and LEN_W = 4, and holds `refTick` high. With those values one tick takes four clock cycles and a length of 3 expires twelve cycles after enable. That makes the exact expiry edge, the restart reload, the hold while disabled and the second expiry of dual mode reachable within a few dozen cycles. RST_PULSE keeps its default of 16, so the whole width of the reset pulse is measured edge by edge.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;

  // Register offsets (byte addresses)
  localparam logic [7:0] OFS_MODE    = 8'h00;
  localparam logic [7:0] OFS_LENGTH  = 8'h04;
  localparam logic [7:0] OFS_RESTART = 8'h08;
  localparam logic [7:0] OFS_SWRST   = 8'h14;

  // Key patterns
  localparam logic [7:0]  MODE_KEY    = 8'h22;
  localparam logic [4:0]  LENGTH_KEY  = 5'h08;
  localparam logic [31:0] RESTART_KEY = 32'h0000_1971;
  localparam logic [31:0] SWRST_KEY   = 32'h0000_1209;

  // Mode register fields
  typedef struct packed {
    logic dual;
    logic irqMode;
    logic extEn;
    logic en;
  } wdtMode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic restart;
    logic swReset;
  } wdtStrobe_t;

endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import keyed_wdt_pkg::*;
#(
  parameter int LEN_W  = 11,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output wdtMode_t          mode,
  output logic [LEN_W-1:0]  lenVal,
  output wdtStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] A_MODE    = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_LENGTH  = ADDR_W'(OFS_LENGTH);
  localparam logic [ADDR_W-1:0] A_RESTART = ADDR_W'(OFS_RESTART);
  localparam logic [ADDR_W-1:0] A_SWRST   = ADDR_W'(OFS_SWRST);

  logic hitMode;
  logic hitLength;
  logic modeKeyOk;
  logic lenKeyOk;

  assign hitMode   = wrEn && (addr == A_MODE);
  assign hitLength = wrEn && (addr == A_LENGTH);
  assign modeKeyOk = (wdata[31:24] == MODE_KEY);
  assign lenKeyOk  = (wdata[4:0] == LENGTH_KEY);

  // Keyed strobes towards the datapath
  always_comb begin
    strobe         = '0;
    strobe.restart = wrEn && (addr == A_RESTART) && (wdata == RESTART_KEY);
    strobe.swReset = wrEn && (addr == A_SWRST) && (wdata == SWRST_KEY);
  end

  // Mode and length storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode   <= '0;
      lenVal <= '1;
    end else begin
      if (hitMode && modeKeyOk) begin
        mode.en      <= wdata[0];
        mode.extEn   <= wdata[2];
        mode.irqMode <= wdata[3];
        mode.dual    <= wdata[6];
      end
      if (hitLength && lenKeyOk) begin
        lenVal <= wdata[5 +: LEN_W];
      end
    end
  end

  // Read mux
  always_comb begin
    unique case (addr)
      A_MODE: begin
        rdata = {25'd0, mode.dual, 2'b00, mode.irqMode, mode.extEn, 1'b0, mode.en};
      end
      A_LENGTH: begin
        rdata = 32'(lenVal) << 5;
      end
      default: begin
        rdata = '0;
      end
    endcase
  end

  a_r2_bad_mode_key_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (hitMode && !modeKeyOk) |=> $stable(mode));

  a_r3_bad_length_key_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (hitLength && !lenKeyOk) |=> $stable(lenVal));

  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.restart && strobe.swReset));

endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import keyed_wdt_pkg::*;
#(
  parameter int PRESCALE_W = 9,
  parameter int LEN_W      = 11,
  parameter int RST_PULSE  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refTick,
  input  wdtMode_t         mode,
  input  logic [LEN_W-1:0] lenVal,
  input  wdtStrobe_t       strobe,
  output logic             rstOut,
  output logic             irqOut
);

  localparam int PULSE_W = $clog2(RST_PULSE + 1);

  logic [PRESCALE_W-1:0] presc;
  logic [LEN_W-1:0]      count;
  logic [PULSE_W-1:0]    pulse;
  logic                  irqQ;
  logic                  advance;
  logic                  tick;
  logic                  expire;
  logic                  rstTrig;

  assign advance = mode.en && refTick;
  assign tick    = advance && (presc == '1);
  assign expire  = tick && (count <= LEN_W'(1));

  // A watchdog reset is asked for by:
  //   - plain mode: any expiry;
  //   - dual mode: an expiry while the interrupt is still pending.
  // Either case needs the reset-output enable. A keyed software reset
  // needs nothing else.
  assign rstTrig = strobe.swReset ||
                   (expire && mode.extEn &&
                    (!mode.irqMode || (mode.dual && irqQ)));

  // Prescaler and down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc <= '0;
      count <= '1;
    end else if (strobe.restart) begin
      presc <= '0;
      count <= lenVal;
    end else if (advance) begin
      presc <= presc + 1'b1;
      if (tick) begin
        count <= expire ? lenVal : count - 1'b1;
      end
    end
  end

  // Sticky interrupt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqQ <= 1'b0;
    end else if (strobe.restart) begin
      irqQ <= 1'b0;
    end else if (expire && mode.irqMode) begin
      irqQ <= 1'b1;
    end
  end

  // Reset pulse stretcher, timed in reference ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulse <= '0;
    end else if (rstTrig) begin
      pulse <= PULSE_W'(RST_PULSE);
    end else if (refTick && (pulse != '0)) begin
      pulse <= pulse - 1'b1;
    end
  end

  assign rstOut = (pulse != '0);
  assign irqOut = irqQ;

  a_r11_swreset_asserts: assert property (@(posedge clk) disable iff (!rstN)
    strobe.swReset |=> rstOut);

  a_r8_expire_resets: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !mode.irqMode && mode.extEn) |=> rstOut);

  a_r7_hold_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (!mode.en && !strobe.restart) |=> ($stable(count) && $stable(presc)));

  a_r6_restart_clears_irq: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> !irqOut);

  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !strobe.restart) |=> irqOut);

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import keyed_wdt_pkg::*;
#(
  parameter int PRESCALE_W = 9,
  parameter int LEN_W      = 11,
  parameter int RST_PULSE  = 16,
  parameter int ADDR_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rstOut,
  output logic              irqOut
);

  wdtMode_t         mode;
  wdtStrobe_t       strobe;
  logic [LEN_W-1:0] lenVal;

  wdt_ctrl #(
    .LEN_W  (LEN_W),
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .mode   (mode),
    .lenVal (lenVal),
    .strobe (strobe)
  );

  wdt_datapath #(
    .PRESCALE_W (PRESCALE_W),
    .LEN_W      (LEN_W),
    .RST_PULSE  (RST_PULSE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .refTick (refTick),
    .mode    (mode),
    .lenVal  (lenVal),
    .strobe  (strobe),
    .rstOut  (rstOut),
    .irqOut  (irqOut)
  );

endmodule

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;

  localparam int PRESCALE_W = 2;
  localparam int LEN_W      = 4;
  localparam int RST_PULSE  = 16;
  localparam int ADDR_W     = 5;
  localparam int NV         = 9;

  localparam logic [ADDR_W-1:0] A_MODE = 5'h00;
  localparam logic [ADDR_W-1:0] A_LEN  = 5'h04;
  localparam logic [ADDR_W-1:0] A_RST  = 5'h08;
  localparam logic [ADDR_W-1:0] A_SWR  = 5'h14;

  // Register vectors: write address, write data, expected readback from
  // the same register address.
  localparam logic [ADDR_W-1:0] V_ADDR [NV] = '{
    A_MODE, A_MODE, A_LEN, A_LEN, A_MODE, A_MODE, A_LEN, A_RST, A_LEN
  };
  localparam logic [31:0] V_DATA [NV] = '{
    32'h2200_0004, 32'h2100_0049, 32'h0000_0068, 32'h0000_00A9, 32'h22FF_FFFE,
    32'h2200_0000, 32'hFFFF_FFE8, 32'h0000_1234, 32'h0000_0028
  };
  localparam logic [31:0] V_EXP [NV] = '{
    32'h0000_0004, 32'h0000_0004, 32'h0000_0060, 32'h0000_0060, 32'h0000_004C,
    32'h0000_0000, 32'h0000_01E0, 32'h0000_0000, 32'h0000_0020
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              refTick = 1'b1;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              rstOut;
  logic              irqOut;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  keyed_wdt #(
    .PRESCALE_W (PRESCALE_W),
    .LEN_W      (LEN_W),
    .RST_PULSE  (RST_PULSE),
    .ADDR_W     (ADDR_W)
  ) u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .refTick (refTick),
    .wrEn    (wrEn),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .rstOut  (rstOut),
    .irqOut  (irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn  = 1'b1;
    addr  = a;
    wdata = d;
    @(posedge clk);
    #1;
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // Length 3, restart, then enable with the given mode word.
  // The enable write is the reference edge E0.
  task automatic arm(input logic [31:0] modeWord);
    doReset();
    wr(A_LEN, 32'h0000_0068);
    wr(A_RST, 32'h0000_1971);
    wr(A_MODE, modeWord);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;

    // R1: reset state
    cyc(2);
    rstN = 1'b1;
    cyc(1);
    chk("R1 rstOut low", 32'(rstOut), 0);
    chk("R1 irqOut low", 32'(irqOut), 0);
    rd(A_MODE, v);
    chk("R1 mode zero", v, 0);
    rd(A_LEN, v);
    chk("R1 length max", v, 32'h1E0);

    // R2/R3/R4: register vector walk
    for (int i = 0; i < NV; i++) begin
      wr(V_ADDR[i], V_DATA[i]);
      rd(V_ADDR[i], v);
      if (V_ADDR[i] == A_MODE)     chk("R2 mode vector", v, V_EXP[i]);
      else if (V_ADDR[i] == A_LEN) chk("R3 length vector", v, V_EXP[i]);
      else                         chk("R4 zero read", v, V_EXP[i]);
    end
    rd(A_SWR, v);
    chk("R4 swrst reads zero", v, 0);

    // R5/R8: plain expiry at E12, pulse of 16 cycles
    arm(32'h2200_0005);
    cyc(11);
    chk("R5 no reset before expiry", 32'(rstOut), 0);
    cyc(1);
    chk("R5 reset at expiry", 32'(rstOut), 1);
    wr(A_MODE, 32'h2200_0004);
    cyc(14);
    chk("R8 pulse still high", 32'(rstOut), 1);
    cyc(1);
    chk("R8 pulse ended", 32'(rstOut), 0);

    // R8: reset-output enable clear suppresses reset
    arm(32'h2200_0001);
    cyc(14);
    chk("R8 extEn clear no reset", 32'(rstOut), 0);

    // R6: good restart at E9 moves expiry to E21
    arm(32'h2200_0005);
    cyc(8);
    wr(A_RST, 32'h0000_1971);
    cyc(11);
    chk("R6 restart delays expiry", 32'(rstOut), 0);
    cyc(1);
    chk("R6 expiry after restart", 32'(rstOut), 1);

    // R6: wrong restart value leaves expiry at E12
    arm(32'h2200_0005);
    cyc(8);
    wr(A_RST, 32'h0000_1970);
    cyc(2);
    chk("R6 bad restart no early reset", 32'(rstOut), 0);
    cyc(1);
    chk("R6 bad restart ignored", 32'(rstOut), 1);

    // R7: disable holds prescaler and counter
    arm(32'h2200_0005);
    cyc(6);
    wr(A_MODE, 32'h2200_0004);
    cyc(20);
    chk("R7 disabled no reset", 32'(rstOut), 0);
    wr(A_MODE, 32'h2200_0005);
    cyc(4);
    chk("R7 resumed not yet expired", 32'(rstOut), 0);
    cyc(1);
    chk("R7 resumed expiry", 32'(rstOut), 1);

    // R9: interrupt mode without dual
    arm(32'h2200_000D);
    cyc(11);
    chk("R9 irq low before expiry", 32'(irqOut), 0);
    cyc(1);
    chk("R9 irq at expiry", 32'(irqOut), 1);
    chk("R9 no reset at expiry", 32'(rstOut), 0);
    cyc(13);
    chk("R9 irq sticky", 32'(irqOut), 1);
    chk("R9 no reset on second expiry", 32'(rstOut), 0);
    wr(A_RST, 32'h0000_1971);
    chk("R6 restart clears irq", 32'(irqOut), 0);

    // R10: dual mode, second expiry resets
    arm(32'h2200_004D);
    cyc(12);
    chk("R10 irq first", 32'(irqOut), 1);
    chk("R10 no reset first", 32'(rstOut), 0);
    cyc(11);
    chk("R10 no reset before second", 32'(rstOut), 0);
    cyc(1);
    chk("R10 reset on second expiry", 32'(rstOut), 1);

    // R11: software reset regardless of enable
    doReset();
    wr(A_SWR, 32'h0000_1208);
    chk("R11 wrong value ignored", 32'(rstOut), 0);
    wr(A_SWR, 32'h0000_1209);
    chk("R11 software reset", 32'(rstOut), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule